// File: doc/BRIEF.md
# Asynchronous DRAM controller

This block sits between a simple host request port and a one-bit-wide asynchronous DRAM whose row and column addresses share one set of address pins. The host presents a read or write request with a word address, one data bit and a write flag on a valid/ready handshake. The controller turns each request into strobe sequences on the row strobe, the column strobe and the write enable. Read data returns on a one-cycle response strobe. All delays are whole clock cycles, and each one is set by a parameter.

After reset the controller waits out a long power-up pause. It then runs a series of refresh cycles in which the column strobe drops before the row strobe, and only after that does it take host requests. In normal operation it starts one such refresh at a fixed interval. Writes are always early writes: write enable falls before the column strobe. While a row is open, further requests to the same row are served as fast page column cycles and the row strobe stays low. The open row closes when a request targets another row, when a refresh falls due, or when the row strobe would otherwise stay low too long.

Top module: `dram_ctl`

## Requirements
- R1: During and right after reset the row strobe, column strobe and write enable are all high (inactive), `req_ready` is low and `rsp_valid` is low.
- R2: `req_ready` stays low for at least `INIT_CYC` cycles after reset. No request is accepted before exactly `INIT_REFS` refresh cycles have been issued.
- R3: The row is `req_addr[21:11]`, presented on `dram_addr` when the row strobe falls. The column is `req_addr[10:0]`, presented when the column strobe falls.
- R4: Once initialisation ends, one refresh falls due every `REF_INT` cycles, and each one that falls due is issued.
- R5: In a refresh the column strobe is low for at least one cycle before the row strobe falls, and write enable stays high the whole time.
- R6: A write drives write enable low at least one cycle before the column strobe falls. Write enable never falls while the column strobe is low. The bit is stored at the addressed location.
- R7: Between two low phases the row strobe stays high for at least `T_RP` cycles.
- R8: The row strobe is never low for more than `MAX_RAS` consecutive cycles. A same-row stream longer than that is split over several row openings.
- R9: A request to the open row is served with a new column strobe cycle and no new row strobe fall.
- R10: Between two column cycles of one open row the column strobe is high for at least `T_CP` cycles.
- R11: For a read, `rsp_valid` pulses for exactly one cycle and carries the bit sampled at the end of a `T_CAS`-cycle column strobe low phase. Responses come in request order.
- R12: A refresh that falls due while a row is open closes the row at a column boundary and runs before the next host request.
- R13: A request is accepted in the cycle where `req_valid` and `req_ready` are both high. Each accepted read gives exactly one response and a write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper half |
| req_wdata | input | 1 | Write data bit |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 1 | Read data bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_din | output | 1 | Data to the memory |
| dram_dout | input | 1 | Data from the memory |

## Verification
The bench builds the controller with a 60-cycle power-up pause, a 300-cycle refresh interval and a 40-cycle limit on row strobe low time, and keeps eight start-up refreshes. With these values the whole start-up sequence, several refresh periods, page streams cut short by the row strobe limit, and refreshes that fall due in the middle of a stream all fit into a short run. A clocked memory model behind the pins stores data, counts refreshes and row openings, and measures precharge and strobe widths.

// File: rtl/dram_ctl.sv
module dram_ctl #(
  parameter int A_W       = 11,
  parameter int INIT_CYC  = 20000,
  parameter int INIT_REFS = 8,
  parameter int REF_INT   = 1560,
  parameter int MAX_RAS   = 1000,
  parameter int T_RP      = 5,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 4,
  parameter int T_CP      = 1,
  parameter int T_CSR     = 1,
  parameter int T_RASR    = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [2*A_W-1:0] req_addr,
  input  logic           req_wdata,
  output logic           rsp_valid,
  output logic           rsp_rdata,
  output logic           dram_ras_n,
  output logic           dram_cas_n,
  output logic           dram_we_n,
  output logic [A_W-1:0] dram_addr,
  output logic           dram_din,
  input  logic           dram_dout
);
  localparam int AW = 2 * A_W;
  localparam int TW = $clog2(INIT_CYC + REF_INT + MAX_RAS + 16);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam logic [TW-1:0] LIM      = TW'(MAX_RAS - T_CAS - T_CP - 2);
  localparam logic [TW-1:0] REF_LAST = TW'(REF_INT - 1);

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_ROW, S_COL, S_CAS, S_PAGE, S_PRE, S_RCS, S_RRAS
  } st_t;

  st_t            st;
  logic [TW-1:0]  tmr, ras_cnt, ref_cnt;
  logic [IW-1:0]  init_left;
  logic           init_done, ref_due;
  logic [A_W-1:0] row_q, col_q;
  logic           wr_q, wd_q;

  logic row_hit, page_ok, accept, ref_hit, ref_take;

  assign row_hit   = req_addr[AW-1:A_W] == row_q;
  assign page_ok   = (st == S_PAGE) && (tmr == '0) && !ref_due && (ras_cnt < LIM) && row_hit;
  assign req_ready = ((st == S_IDLE) && !ref_due) || page_ok;
  assign accept    = req_valid && req_ready;
  assign ref_hit   = init_done && (ref_cnt == REF_LAST);
  assign ref_take  = (st == S_IDLE) && ref_due;

  assign dram_ras_n = !(st inside {S_ROW, S_COL, S_CAS, S_PAGE, S_RRAS});
  assign dram_cas_n = !(st inside {S_CAS, S_RCS, S_RRAS});
  assign dram_we_n  = !((st == S_COL || st == S_CAS) && wr_q);
  assign dram_addr  = (st == S_ROW) ? row_q :
                      (st == S_COL || st == S_CAS) ? col_q : '0;
  assign dram_din   = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_INIT;
      tmr       <= TW'(INIT_CYC - 1);
      ras_cnt   <= '0;
      ref_cnt   <= '0;
      ref_due   <= 1'b0;
      init_left <= IW'(INIT_REFS);
      init_done <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (tmr != '0) tmr <= tmr - 1'b1;
      ras_cnt <= dram_ras_n ? '0 : ras_cnt + 1'b1;
      ref_cnt <= (!init_done || ref_hit) ? '0 : ref_cnt + 1'b1;
      ref_due <= ref_hit | (ref_due & ~ref_take);

      case (st)
        S_INIT: if (tmr == '0) begin
          st        <= S_RCS;
          tmr       <= TW'(T_CSR - 1);
          init_left <= init_left - 1'b1;
        end
        S_IDLE: if (ref_due) begin
          st  <= S_RCS;
          tmr <= TW'(T_CSR - 1);
        end else if (accept) begin
          row_q <= req_addr[AW-1:A_W];
          col_q <= req_addr[A_W-1:0];
          wr_q  <= req_write;
          wd_q  <= req_wdata;
          st    <= S_ROW;
          tmr   <= TW'(T_RCD - 1);
        end
        S_ROW: if (tmr == '0) st <= S_COL;
        S_COL: begin
          st  <= S_CAS;
          tmr <= TW'(T_CAS - 1);
        end
        S_CAS: if (tmr == '0) begin
          rsp_valid <= !wr_q;
          rsp_rdata <= dram_dout;
          st        <= S_PAGE;
          tmr       <= TW'(T_CP - 1);
        end
        S_PAGE: if (accept) begin
          col_q <= req_addr[A_W-1:0];
          wr_q  <= req_write;
          wd_q  <= req_wdata;
          st    <= S_COL;
        end else if ((tmr == '0) && (ref_due || ras_cnt >= LIM || (req_valid && !row_hit))) begin
          st  <= S_PRE;
          tmr <= TW'(T_RP - 1);
        end
        S_PRE: if (tmr == '0) begin
          if (init_left != '0) begin
            st        <= S_RCS;
            tmr       <= TW'(T_CSR - 1);
            init_left <= init_left - 1'b1;
          end else begin
            st        <= S_IDLE;
            init_done <= 1'b1;
          end
        end
        S_RCS: if (tmr == '0) begin
          st  <= S_RRAS;
          tmr <= TW'(T_RASR - 1);
        end
        S_RRAS: if (tmr == '0) begin
          st  <= S_PRE;
          tmr <= TW'(T_RP - 1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk #(
  parameter int INIT_CYC = 20000,
  parameter int MAX_RAS  = 1000,
  parameter int T_RP     = 5,
  parameter int T_CP     = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  int cyc, ras_hi, ras_lo, cas_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc    <= 0;
      ras_hi <= 0;
      ras_lo <= 0;
      cas_hi <= 0;
    end else begin
      if (cyc < INIT_CYC) cyc <= cyc + 1;
      ras_hi <= ras_n ? ras_hi + 1 : 0;
      ras_lo <= ras_n ? 0 : ras_lo + 1;
      cas_hi <= cas_n ? cas_hi + 1 : 0;
    end
  end

  assert_no_ready_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < INIT_CYC) |-> !req_ready);

  assert_cbr_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> we_n);

  assert_cbr_cas_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  assert_we_before_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !we_n) |-> $past(!we_n));

  assert_we_not_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> cas_n);

  assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi >= T_RP));

  assert_ras_low_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (ras_lo < MAX_RAS));

  assert_cas_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> (cas_hi >= T_CP));

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind dram_ctl dram_ctl_chk #(
  .INIT_CYC(INIT_CYC), .MAX_RAS(MAX_RAS), .T_RP(T_RP), .T_CP(T_CP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n)
);

// File: tb/dram_ctl_tb_top.sv
module dram_ctl_tb_top;
  localparam int INIT_CYC = 60, INIT_REFS = 8, REF_INT = 300, MAX_RAS = 40;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 3, T_CP = 1, T_CSR = 1, T_RASR = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_wdata = 0;
  logic [21:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata;
  logic ras_n, cas_n, we_n, din, dout;
  logic [10:0] addr;

  always #5 clk = ~clk;

  dram_ctl #(.A_W(11), .INIT_CYC(INIT_CYC), .INIT_REFS(INIT_REFS), .REF_INT(REF_INT),
             .MAX_RAS(MAX_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
             .T_CSR(T_CSR), .T_RASR(T_RASR)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_addr(addr), .dram_din(din), .dram_dout(dout));

  // clocked memory model at the pins
  bit mem [int];
  int refs = 0, ras_falls = 0, bad_cbr = 0, late_we = 0;
  int min_pre = 1000000, max_lo = 0, min_cp = 1000000;
  int hi_run = 0, lo_run = 0, chi_run = 0;
  logic [10:0] row_l = '0, last_row = '0, last_col = '0;
  logic rd_q = 0, p_ras = 1, p_cas = 1, p_we = 1;
  assign dout = rd_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_we = 1;
    end else begin
      if (!ras_n && p_ras) begin
        if (hi_run < min_pre) min_pre = hi_run;
        if (!cas_n) begin
          refs++;
          if (!we_n) bad_cbr++;
        end else begin
          ras_falls++;
          row_l = addr;
        end
      end
      if (!cas_n && p_cas && !ras_n) begin
        last_row = row_l;
        last_col = addr;
        if (chi_run < min_cp) min_cp = chi_run;
        if (!we_n) mem[int'({row_l, addr})] = din;
        else rd_q = mem.exists(int'({row_l, addr})) ? mem[int'({row_l, addr})] : 1'b0;
      end
      if (!we_n && p_we && !cas_n) late_we++;
      hi_run  = ras_n ? hi_run + 1 : 0;
      lo_run  = ras_n ? 0 : lo_run + 1;
      if (lo_run > max_lo) max_lo = lo_run;
      chi_run = cas_n ? chi_run + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  // scoreboard
  int checks = 0, fails = 0, reads = 0, rsps = 0, cyc = 0;
  bit exp_q[$];
  bit sh [int];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsps++;
      if (exp_q.size() == 0) check(0, "R13 unexpected response", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(rsp_rdata == e, "R11 read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  // called at a falling edge, returns at a falling edge after acceptance
  task automatic xfer(bit wr, logic [21:0] a, bit d);
    bit r;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      #4 r = req_ready;
      @(posedge clk);
      if (!r) @(negedge clk);
    end while (!r);
    if (wr) sh[int'(a)] = d;
    else begin
      exp_q.push_back(sh.exists(int'(a)) ? sh[int'(a)] : 1'b0);
      reads++;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic bit pat(logic [21:0] a);
    return a[0] ^ a[5] ^ a[13] ^ a[20];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    int r0, f0, d;
    logic [21:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && we_n, "R1 strobes idle", int'({ras_n, cas_n, we_n}), 7);
    check(!req_ready && !rsp_valid, "R1 ready/rsp low", int'({req_ready, rsp_valid}), 0);

    // R2 initialisation
    while (!req_ready) @(negedge clk);
    check(cyc >= INIT_CYC, "R2 power-up pause", cyc, INIT_CYC);
    check(refs == INIT_REFS, "R2 start-up refreshes", refs, INIT_REFS);

    // R3 address split, R6 early write
    a = {11'h5A3, 11'h0C7};
    xfer(1, a, 1);
    repeat (10) @(negedge clk);
    check(last_row == 11'h5A3, "R3 row on A pins", int'(last_row), 'h5A3);
    check(last_col == 11'h0C7, "R3 column on A pins", int'(last_col), 'h0C7);

    // R3/R6/R11 scattered writes then reads (row misses)
    for (int i = 0; i < 12; i++) begin
      logic [21:0] b;
      b = 22'((i * 22'h04D3A1) ^ 22'h2F0F1);
      xfer(1, b, pat(b));
    end
    for (int i = 0; i < 12; i++) xfer(0, 22'((i * 22'h04D3A1) ^ 22'h2F0F1), 0);
    xfer(0, a, 0);

    // R9 short page burst
    repeat (8) @(negedge clk);
    r0 = refs; f0 = ras_falls;
    for (int c = 0; c < 4; c++) begin
      logic [21:0] b;
      b = {11'h155, 11'(c * 37 + 5)};
      xfer(1, b, ~pat(b));
    end
    repeat (12) @(negedge clk);
    check((ras_falls - f0) == 1 + (refs - r0), "R9 page burst single row open",
          ras_falls - f0, 1 + refs - r0);
    for (int c = 0; c < 4; c++) xfer(0, {11'h155, 11'(c * 37 + 5)}, 0);

    // R8 long same-row stream is split
    repeat (8) @(negedge clk);
    r0 = refs; f0 = ras_falls;
    for (int c = 0; c < 12; c++) begin
      logic [21:0] b;
      b = {11'h2AA, 11'(c * 91)};
      xfer(1, b, pat(b));
    end
    repeat (12) @(negedge clk);
    d = (ras_falls - f0) - (refs - r0);
    check(d >= 2, "R8 stream split by RAS limit", d, 2);

    // R4 refresh rate while idle
    r0 = refs;
    repeat (3 * REF_INT) @(negedge clk);
    d = refs - r0;
    check(d >= 2 && d <= 4, "R4 refresh interval", d, 3);

    // R12 refresh during continuous page traffic
    r0 = refs;
    for (int i = 0; i < 100; i++) xfer(0, {11'h2AA, 11'((i % 12) * 91)}, 0);
    d = refs - r0;
    check(d >= 1, "R12 refresh inside stream", d, 1);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R13 all reads answered", exp_q.size(), 0);
    check(rsps == reads, "R13 one response per read", rsps, reads);
    check(bad_cbr == 0, "R5 WRITE high in refresh", bad_cbr, 0);
    check(late_we == 0, "R6 no late write enable", late_we, 0);
    check(min_pre >= T_RP, "R7 RAS precharge", min_pre, T_RP);
    check(max_lo <= MAX_RAS, "R8 RAS low max", max_lo, MAX_RAS);
    check(min_cp >= T_CP, "R10 CAS precharge", min_cp, T_CP);
    finish_run();
  end
endmodule